// File: doc/BRIEF.md
# Two-Speed Offset-Nulling Step Controller

This block is the digital core of a sampled offset-cancellation loop. A one-bit comparator outside the block reports whether the residual error is above zero. The block samples that bit on sample strobes. It holds the last decision on a registered output. On every sample it moves a signed correction word by one programmable step, against the sign of the error. A converter outside the block turns that word back into an analog correction.

Right after reset the block samples on every clock cycle, so that a large initial offset is removed quickly. The first time the held decision flips against an earlier sample, the loop has crossed null. The block raises a flag that stays set, and from then on it samples once per period of a programmable divider. A two-bit rate select picks that period. This gives quick acquisition and slow, low-noise tracking afterwards. Driving reset low again returns the block to the fast acquisition mode.

Top module: `offset_null_seq`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is sampled low, the block clears `dec_o` to 0, `corr_o` to 0 and `null_o` to 0 at the next rising clock edge.
- R2: While `null_o` is 0, a sample is taken on every rising clock edge, so `corr_o` changes by one step on every cycle, barring saturation.
- R3: The first sample after reset only sets the reference value and never counts as a crossing. `null_o` rises on the same edge at which a later sample first latches a value different from the held decision. It then stays 1 until reset.
- R4: While `null_o` is 1, samples are spaced by a fixed number of cycles chosen by `rate_sel_i`: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 128 and 2'b11 gives 1024.
- R5: `rate_sel_i` is captured on each sample edge. A change made during a period does not alter that period. The new spacing applies from the following period.
- R6: On each sample edge, `dec_o` takes the value of `cmp_i`. Between samples it holds, whatever `cmp_i` does.
- R7: On each sample edge, `corr_o` decreases by `step_i` when `cmp_i` is 1 and increases by `step_i` when `cmp_i` is 0. Both values are read as two's complement.
- R8: `corr_o` saturates at 32767 and at -32768 and never wraps.
- R9: Asserting reset after null has been reached returns the block to per-cycle sampling, with the correction word and the flag cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel_i | input | 2 | Sample-period select for the tracking mode |
| cmp_i | input | 1 | Comparator decision, 1 means the error is positive |
| step_i | input | 8 | Unsigned correction step size |
| dec_o | output | 1 | Decision held from the last sample |
| corr_o | output | 16 | Signed correction word |
| null_o | output | 1 | Set once the first crossing has been seen |

## Verification
The bench targets several corner cases:
- A nonzero first sample after reset. A design that treated this as a crossing would leave fast mode at once.
- The exact sample spacing for every select code, including a select change in the middle of a period. A design that decoded the select live would cut that period short.
- Saturation at both ends with the largest step. A wrapping adder would jump to the far end of the range.
- Held decisions between slow samples, and a closed plant loop that must settle within one step of its target.
- Reset during tracking. A design that kept the flag would stay slow after reset.

// File: rtl/offset_null_pkg.sv
package offset_null_pkg;

    typedef enum logic [1:0] {
        RATE_A = 2'b00,
        RATE_B = 2'b01,
        RATE_C = 2'b10,
        RATE_D = 2'b11
    } rate_sel_e;

    function automatic int unsigned div_of(input logic [1:0] sel,
                                           input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c,
                                           input int unsigned d);
        case (rate_sel_e'(sel))
            RATE_A:  return a;
            RATE_B:  return b;
            RATE_C:  return c;
            default: return d;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c,
                                         input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/offset_null_div.sv
module offset_null_div
    import offset_null_pkg::*;
#(
    parameter int unsigned DIV_A = 4,
    parameter int unsigned DIV_B = 16,
    parameter int unsigned DIV_C = 128,
    parameter int unsigned DIV_D = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fast_i,
    input  logic [1:0] sel_i,
    output logic       stb_o
);
    localparam int unsigned MAX_DIV = max4(DIV_A, DIV_B, DIV_C, DIV_D);
    localparam int unsigned CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] term;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    stb;

    always_comb begin
        st_d = st_q;
        stb  = fast_i || (st_q.cnt == st_q.term);
        if (stb) begin
            st_d.cnt  = '0;
            st_d.term = CNT_W'(div_of(sel_i, DIV_A, DIV_B, DIV_C, DIV_D) - 1);
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_o = stb;

endmodule

// File: rtl/offset_null_track.sv
module offset_null_track (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic cmp_i,
    output logic dec_o,
    output logic null_o
);
    typedef struct packed {
        logic dec;
        logic seen;
        logic crossed;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            st_d.dec  = cmp_i;
            st_d.seen = 1'b1;
            if (st_q.seen && (cmp_i != st_q.dec)) st_d.crossed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_o  = st_q.dec;
    assign null_o = st_q.crossed;

endmodule

// File: rtl/offset_null_acc.sv
module offset_null_acc #(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned STEP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb_i,
    input  logic                    down_i,
    input  logic [STEP_W-1:0]       step_i,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int unsigned EXT_W = ACC_W + 2;
    localparam logic signed [EXT_W-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t                 st_d, st_q;
    logic signed [EXT_W-1:0] mag;
    logic signed [EXT_W-1:0] wide;
    logic signed [EXT_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        mag  = signed'({{(EXT_W-STEP_W){1'b0}}, step_i});
        wide = {{2{st_q.acc[ACC_W-1]}}, st_q.acc};
        sum  = down_i ? (wide - mag) : (wide + mag);
        if (stb_i) begin
            if (sum > MAXV)      st_d.acc = MAXV[ACC_W-1:0];
            else if (sum < MINV) st_d.acc = MINV[ACC_W-1:0];
            else                 st_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/offset_null_seq.sv
module offset_null_seq #(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned STEP_W = 8,
    parameter int unsigned DIV_A  = 4,
    parameter int unsigned DIV_B  = 16,
    parameter int unsigned DIV_C  = 128,
    parameter int unsigned DIV_D  = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              rate_sel_i,
    input  logic                    cmp_i,
    input  logic [STEP_W-1:0]       step_i,
    output logic                    dec_o,
    output logic signed [ACC_W-1:0] corr_o,
    output logic                    null_o
);
    logic smp_stb;
    logic crossed;

    offset_null_div #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C),
        .DIV_D (DIV_D)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast_i (!crossed),
        .sel_i  (rate_sel_i),
        .stb_o  (smp_stb)
    );

    offset_null_track u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (smp_stb),
        .cmp_i  (cmp_i),
        .dec_o  (dec_o),
        .null_o (crossed)
    );

    offset_null_acc #(
        .ACC_W  (ACC_W),
        .STEP_W (STEP_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (smp_stb),
        .down_i (cmp_i),
        .step_i (step_i),
        .acc_o  (corr_o)
    );

    assign null_o = crossed;

endmodule

// File: rtl/offset_null_chk.sv
module offset_null_chk #(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned STEP_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stb,
    input logic                    cmp,
    input logic [STEP_W-1:0]       step,
    input logic                    dec,
    input logic signed [ACC_W-1:0] corr,
    input logic                    nul
);
    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (corr == '0 && !nul && !dec));

    p_fast_every_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nul |-> stb);

    p_null_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nul |=> nul);

    p_null_on_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nul) |-> !$stable(dec));

    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (dec == $past(cmp)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(dec) && $stable(corr));

    p_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && cmp && corr != MINV && step != '0) |=> (corr < $past(corr)));

    p_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !cmp && corr != MAXV && step != '0) |=> (corr > $past(corr)));

    p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !cmp && corr == MAXV) |=> (corr == MAXV));

    p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && cmp && corr == MINV) |=> (corr == MINV));

endmodule

bind offset_null_seq offset_null_chk #(
    .ACC_W  (ACC_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (smp_stb),
    .cmp   (cmp_i),
    .step  (step_i),
    .dec   (dec_o),
    .corr  (corr_o),
    .nul   (null_o)
);

// File: tb/tb_offset_null_seq.sv
`timescale 1ns/1ps
module tb_offset_null_seq;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         sel = 2'b00;
    logic               cmp = 1'b0;
    logic [7:0]         step = 8'd3;
    logic               dec;
    logic signed [15:0] corr;
    logic               nul;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    offset_null_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (sel),
        .cmp_i      (cmp),
        .step_i     (step),
        .dec_o      (dec),
        .corr_o     (corr),
        .null_o     (nul)
    );

    always #5 clk = ~clk;

    function automatic int ratio(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 16;
            2'b10:   return 128;
            default: return 1024;
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_change(output int k);
        logic signed [15:0] prev;
        prev = corr;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (corr == prev && k < 3000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int k;
        longint e;
        logic [1:0] old;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(corr == 0, "R1 corr", corr, 0);
        chk(nul == 0, "R1 null", nul, 0);
        chk(dec == 0, "R1 dec", dec, 0);

        // R2 / R7: per-cycle increments before null
        rst_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            chk(corr == 3 * i, "R2 fast step", corr, 3 * i);
            chk(nul == 0, "R3 no flip yet", nul, 0);
        end
        cmp = 1'b1;
        @(negedge clk);
        chk(dec == 1, "R6 latch", dec, 1);
        chk(nul == 1, "R3 null on flip", nul, 1);
        chk(corr == 15, "R7 down step", corr, 15);

        // R4 / R5: spacing per select, change mid-period
        step = 8'd1;
        wait_change(k);
        chk(k == 4, "R4 first slow period", k, 4);
        old = 2'b00;
        for (int j = 0; j < 4; j++) begin
            logic [1:0] nw;
            nw = 2'((j + 1) % 4);
            sel = nw;
            wait_change(k);
            chk(k == ratio(old), "R5 period keeps old select", k, ratio(old));
            wait_change(k);
            chk(k == ratio(nw), "R4 new select spacing", k, ratio(nw));
            old = nw;
        end
        chk(nul == 1, "R3 sticky", nul, 1);

        // R6: decision held between slow samples
        cmp = 1'b0;
        @(negedge clk);
        chk(dec == 1, "R6 hold 1", dec, 1);
        @(negedge clk);
        chk(dec == 1, "R6 hold 2", dec, 1);
        wait_change(k);
        chk(k == 2, "R6 next sample time", k, 2);
        chk(dec == 0, "R6 new decision", dec, 0);

        // R9: reset after null
        rst_n = 1'b0;
        step = 8'd2;
        @(negedge clk);
        chk(corr == 0, "R9 corr cleared", corr, 0);
        chk(nul == 0, "R9 null cleared", nul, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(corr == 2, "R9 fast again 1", corr, 2);
        @(negedge clk);
        chk(corr == 4, "R9 fast again 2", corr, 4);

        // R8: positive saturation
        cmp = 1'b0;
        step = 8'd255;
        do_reset();
        for (int i = 1; i <= 140; i++) begin
            @(negedge clk);
            e = (255 * i > 32767) ? 32767 : 255 * i;
            chk(corr == e, "R8 high clamp", corr, e);
        end

        // R3 / R8: first sample 1 is no crossing, negative saturation
        cmp = 1'b1;
        do_reset();
        for (int i = 1; i <= 140; i++) begin
            @(negedge clk);
            e = (-255 * i < -32768) ? -32768 : -255 * i;
            chk(corr == e, "R8 low clamp", corr, e);
        end
        chk(nul == 0, "R3 first sample not a flip", nul, 0);

        // R3 / R7: closed loop settles near target
        sel = 2'b00;
        step = 8'd7;
        cmp = 1'b0;
        do_reset();
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            cmp = (corr > 16'sd1000);
        end
        chk(nul == 1, "R3 loop crossed", nul, 1);
        e = corr - 1000;
        if (e < 0) e = -e;
        chk(e <= 7, "R7 loop settles", corr, 1000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule